// File: doc/BRIEF.md
# DDR2 Command Bus Decoder

This block watches the command pins of a DDR2 memory channel and turns every rising clock edge into one decoded event. Chip select, the three active-low strobes (row strobe, column strobe, write enable), the bank pins, the address bits and clock enable are sampled together. One cycle later the block presents a one-hot command indication together with the fields that matter for that command: the target bank, the row to open, the column to access, or the mode register and opcode being loaded.

Address bit 10 is interpreted by context. On a read or write it requests auto-precharge once the burst completes. On a precharge it chooses between closing the addressed bank and closing every bank. The block also keeps an open-row flag for each bank. It raises a one-cycle sequence error when a command breaks the open/closed rules, for example an activate to a bank that is already open, or a read or write to a bank that has no open row. A monitor, a protocol checker or a memory model can sit behind it and use these decoded events directly.

Top module: `dram_cmd_decode`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are forced to zero on the following cycle and every bank is marked closed.
- R2: When `cke` is high and `cs_n` is high, the indication is DESELECT (bit 10) alone, whatever levels the strobes carry.
- R3: When `cke` is high and `cs_n` is low, {ras_n,cas_n,we_n} decodes as follows: 000 load mode, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 reserved, 111 NOP. The indication bits are 0 load mode, 1 refresh, 2 precharge one bank, 3 precharge all, 4 activate, 5 write, 6 write with auto-precharge, 7 read, 8 read with auto-precharge, 9 NOP, 10 DESELECT, 11 reserved. Outputs appear one cycle after the sampling edge.
- R4: On activate, `cmd_row` carries `addr` and `cmd_bank` carries `ba`, and that bank becomes open. `cmd_row` is zero for every other command.
- R5: On read or write, `cmd_col` carries `addr[9:0]` and `cmd_bank` carries `ba`. With `addr[10]` high, the auto-precharge variant is indicated and the bank is closed. `cmd_col` is zero for every other command.
- R6: On precharge with `addr[10]` low, only bank `ba` closes and `cmd_bank` carries `ba`. With `addr[10]` high, all eight banks close and `cmd_bank` is zero. `cmd_bank` is also zero for load mode, refresh, NOP, reserved, DESELECT and suppressed cycles.
- R7: On load mode, `mr_sel` carries `ba[1:0]` (0 base, 1 to 3 extended registers) and `mr_opcode` carries `addr`. Both outputs are zero for every other command.
- R8: When `cke` is low at a sampling edge, no indication bit is set, all fields are zero, no error is raised and no bank changes state.
- R9: `seq_err` goes high for exactly the cycle of an activate to an open bank, or of a read or write to a closed bank. An erroneous activate leaves the bank open.
- R10: `bank_open` shows the open flag of each bank after the command that is currently indicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low suppresses decoding |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| ba | input | 3 | Bank pins |
| addr | input | 14 | Address pins; bit 10 is context dependent |
| cmd_hot | output | 12 | One-hot command indication, or all zero |
| cmd_bank | output | 3 | Target bank |
| cmd_row | output | 14 | Row address on activate |
| cmd_col | output | 10 | Column address on read or write |
| mr_sel | output | 2 | Mode register selected by load mode |
| mr_opcode | output | 14 | Opcode carried by load mode |
| bank_open | output | 8 | Open-row flag per bank |
| seq_err | output | 1 | Open/closed rule violation for the indicated command |

## Verification
A wrong open flag appears on `bank_open` in the same cycle as the command that corrupted it. It then shows again as a spurious or missing `seq_err` on the next activate, read or write to that bank. Misreading bit 10 appears at once, because the wrong variant bit is set in `cmd_hot` or the wrong set of banks closes. Both symptoms are compared against a model every cycle, so a divergence is caught within one clock of the command that caused it.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int NUM_KINDS = 12;

    // Enum value equals the bit index in the one-hot indication.
    typedef enum logic [3:0] {
        K_LMR  = 4'd0,
        K_REF  = 4'd1,
        K_PRE1 = 4'd2,
        K_PREA = 4'd3,
        K_ACT  = 4'd4,
        K_WR   = 4'd5,
        K_WRA  = 4'd6,
        K_RD   = 4'd7,
        K_RDA  = 4'd8,
        K_NOP  = 4'd9,
        K_DES  = 4'd10,
        K_RSV  = 4'd11,
        K_IDLE = 4'd12
    } kind_e;

    function automatic logic is_column(kind_e k);
        return (k == K_RD) || (k == K_RDA) || (k == K_WR) || (k == K_WRA);
    endfunction

    function automatic logic [NUM_KINDS-1:0] kind_to_hot(kind_e k);
        logic [NUM_KINDS-1:0] h;
        h = '0;
        if (k != K_IDLE) begin
            h = {{(NUM_KINDS-1){1'b0}}, 1'b1} << k;
        end
        return h;
    endfunction

endpackage

// File: rtl/dcd_classify.sv
module dcd_classify
    import dcd_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int AP_POS = 10
) (
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    output kind_e            kind
);

    logic ap;
    assign ap = addr[AP_POS];

    always_comb begin
        if (!cke) begin
            kind = K_IDLE;
        end else if (cs_n) begin
            kind = K_DES;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  kind = K_LMR;
                3'b001:  kind = K_REF;
                3'b010:  kind = ap ? K_PREA : K_PRE1;
                3'b011:  kind = K_ACT;
                3'b100:  kind = ap ? K_WRA : K_WR;
                3'b101:  kind = ap ? K_RDA : K_RD;
                3'b110:  kind = K_RSV;
                default: kind = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/dcd_bank_track.sv
module dcd_bank_track
    import dcd_pkg::*;
#(
    parameter int BA_W = 3,
    localparam int NB  = 1 << BA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  kind_e           kind,
    input  logic [BA_W-1:0] ba,
    output logic [NB-1:0]   open_q,
    output logic            err_d
);

    logic [NB-1:0] open_d;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));
        always_comb begin
            open_d[b] = open_q[b];
            unique case (kind)
                K_ACT:               if (hit) open_d[b] = 1'b1;
                K_PRE1, K_RDA, K_WRA: if (hit) open_d[b] = 1'b0;
                K_PREA:              open_d[b] = 1'b0;
                default:             open_d[b] = open_q[b];
            endcase
        end
    end

    always_comb begin
        err_d = 1'b0;
        if (kind == K_ACT && open_q[ba]) err_d = 1'b1;
        if (is_column(kind) && !open_q[ba]) err_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else     open_q <= open_d;
    end

endmodule

// File: rtl/dcd_field_sel.sv
module dcd_field_sel
    import dcd_pkg::*;
#(
    parameter int BA_W  = 3,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int MR_W  = 2
) (
    input  kind_e            kind,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    output logic [BA_W-1:0]  bank_d,
    output logic [ROW_W-1:0] row_d,
    output logic [COL_W-1:0] col_d,
    output logic [MR_W-1:0]  mr_d,
    output logic [ROW_W-1:0] op_d
);

    always_comb begin
        bank_d = '0;
        row_d  = '0;
        col_d  = '0;
        mr_d   = '0;
        op_d   = '0;
        unique case (kind)
            K_ACT: begin
                bank_d = ba;
                row_d  = addr;
            end
            K_RD, K_RDA, K_WR, K_WRA: begin
                bank_d = ba;
                col_d  = addr[COL_W-1:0];
            end
            K_PRE1: bank_d = ba;
            K_LMR: begin
                mr_d = ba[MR_W-1:0];
                op_d = addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
    import dcd_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int AP_POS = 10,
    parameter int MR_W   = 2,
    localparam int NB    = 1 << BA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     addr,
    output logic [NUM_KINDS-1:0] cmd_hot,
    output logic [BA_W-1:0]      cmd_bank,
    output logic [ROW_W-1:0]     cmd_row,
    output logic [COL_W-1:0]     cmd_col,
    output logic [MR_W-1:0]      mr_sel,
    output logic [ROW_W-1:0]     mr_opcode,
    output logic [NB-1:0]        bank_open,
    output logic                 seq_err
);

    kind_e            kind;
    logic             err_d;
    logic [BA_W-1:0]  bank_d;
    logic [ROW_W-1:0] row_d;
    logic [COL_W-1:0] col_d;
    logic [MR_W-1:0]  mr_d;
    logic [ROW_W-1:0] op_d;

    dcd_classify #(.ROW_W(ROW_W), .AP_POS(AP_POS)) u_cls (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .kind(kind)
    );

    dcd_bank_track #(.BA_W(BA_W)) u_trk (
        .clk(clk), .rst(rst), .kind(kind), .ba(ba),
        .open_q(bank_open), .err_d(err_d)
    );

    dcd_field_sel #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .MR_W(MR_W)) u_fld (
        .kind(kind), .ba(ba), .addr(addr),
        .bank_d(bank_d), .row_d(row_d), .col_d(col_d), .mr_d(mr_d), .op_d(op_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_hot   <= '0;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            mr_sel    <= '0;
            mr_opcode <= '0;
            seq_err   <= 1'b0;
        end else begin
            cmd_hot   <= kind_to_hot(kind);
            cmd_bank  <= bank_d;
            cmd_row   <= row_d;
            cmd_col   <= col_d;
            mr_sel    <= mr_d;
            mr_opcode <= op_d;
            seq_err   <= err_d;
        end
    end

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
    import dcd_pkg::*;
#(
    parameter int BA_W = 3,
    localparam int NB  = 1 << BA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic [NUM_KINDS-1:0] cmd_hot,
    input logic [BA_W-1:0]      cmd_bank,
    input logic [NB-1:0]        bank_open,
    input logic                 seq_err
);

    // R3: at most one indication bit
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_hot));

    a_r2_deselect: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cke) && $past(cs_n)) |-> (cmd_hot == (NUM_KINDS'(1) << K_DES)));

    a_r4_act_opens: assert property (@(posedge clk) disable iff (rst)
        cmd_hot[K_ACT] |-> bank_open[cmd_bank]);

    a_r5_autopre_closes: assert property (@(posedge clk) disable iff (rst)
        (cmd_hot[K_RDA] || cmd_hot[K_WRA]) |-> !bank_open[cmd_bank]);

    a_r6_pre_all: assert property (@(posedge clk) disable iff (rst)
        cmd_hot[K_PREA] |-> (bank_open == '0));

    a_r8_cke_low: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cke)) |-> (cmd_hot == '0 && !seq_err && bank_open == $past(bank_open)));

    a_r9_act_err: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cke) && !$past(cs_n) &&
         $past({ras_n, cas_n, we_n}) == 3'b011 && $past(bank_open[ba])) |-> seq_err);

    a_r1_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_hot == '0 && bank_open == '0 && !seq_err));

endmodule

bind dram_cmd_decode dcd_checker #(.BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .cmd_hot(cmd_hot), .cmd_bank(cmd_bank),
    .bank_open(bank_open), .seq_err(seq_err)
);

// File: tb/tb_dram_cmd_decode.sv
module tb_dram_cmd_decode;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b0;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [11:0] cmd_hot;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [1:0]  mr_sel;
    logic [13:0] mr_opcode;
    logic [7:0]  bank_open;
    logic        seq_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dram_cmd_decode dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cmd_hot(cmd_hot), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .mr_sel(mr_sel), .mr_opcode(mr_opcode),
        .bank_open(bank_open), .seq_err(seq_err)
    );

    // reference model state and expectations
    logic [7:0]  m_open = '0;
    logic [11:0] e_hot = '0;
    logic [2:0]  e_bank = '0;
    logic [13:0] e_row = '0;
    logic [9:0]  e_col = '0;
    logic [1:0]  e_mr = '0;
    logic [13:0] e_op = '0;
    logic        e_err = 1'b0;
    string       e_tag = "R1";
    bit          have_exp = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(32'(cmd_hot), 32'(e_hot), e_tag, "cmd_hot");
        chk(32'(cmd_bank), 32'(e_bank), "R6", "cmd_bank");
        chk(32'(cmd_row), 32'(e_row), "R4", "cmd_row");
        chk(32'(cmd_col), 32'(e_col), "R5", "cmd_col");
        chk(32'(mr_sel), 32'(e_mr), "R7", "mr_sel");
        chk(32'(mr_opcode), 32'(e_op), "R7", "mr_opcode");
        chk(32'(seq_err), 32'(e_err), "R9", "seq_err");
        chk(32'(bank_open), 32'(m_open), "R10", "bank_open");
    endtask

    // called at a falling edge: check last command's result, then drive the next
    task automatic apply(input logic k, input logic cs, input logic [2:0] code,
                         input logic [2:0] b, input logic [13:0] a);
        int kind;
        if (have_exp) compare_all();
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
        if (!k) kind = 12;
        else if (cs) kind = 10;
        else begin
            case (code)
                3'b000: kind = 0;
                3'b001: kind = 1;
                3'b010: kind = a[10] ? 3 : 2;
                3'b011: kind = 4;
                3'b100: kind = a[10] ? 6 : 5;
                3'b101: kind = a[10] ? 8 : 7;
                3'b110: kind = 11;
                default: kind = 9;
            endcase
        end
        e_hot = (kind == 12) ? 12'd0 : (12'd1 << kind);
        e_tag = (kind == 12) ? "R8" : (kind == 10) ? "R2" : "R3";
        e_bank = '0; e_row = '0; e_col = '0; e_mr = '0; e_op = '0; e_err = 1'b0;
        if (kind == 4) begin
            e_bank = b; e_row = a;
            e_err = m_open[b];
            m_open[b] = 1'b1;
        end else if (kind >= 5 && kind <= 8) begin
            e_bank = b; e_col = a[9:0];
            e_err = !m_open[b];
            if (kind == 6 || kind == 8) m_open[b] = 1'b0;
        end else if (kind == 2) begin
            e_bank = b; m_open[b] = 1'b0;
        end else if (kind == 3) begin
            m_open = '0;
        end else if (kind == 0) begin
            e_mr = b[1:0]; e_op = a;
        end
        have_exp = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset with an activate on the pins: must be ignored (R1)
        @(negedge clk);
        cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b011; ba = 3'd4;
        repeat (3) @(negedge clk);
        chk(32'(cmd_hot), 32'd0, "R1", "cmd_hot after reset");
        chk(32'(bank_open), 32'd0, "R1", "bank_open after reset");
        chk(32'(seq_err), 32'd0, "R1", "seq_err after reset");
        chk(32'({cmd_bank, cmd_row, cmd_col, mr_sel, mr_opcode}), 32'd0, "R1", "fields after reset");
        rst = 1'b0;

        // directed: R4 activate, R5 read/write with and without auto-precharge, R9 errors
        apply(1, 0, 3'b011, 3'd2, 14'h1abc);
        apply(1, 0, 3'b101, 3'd2, 14'h0055);  // read, A10 low
        apply(1, 0, 3'b100, 3'd2, 14'h0777);  // write with auto-precharge, closes bank 2
        apply(1, 0, 3'b101, 3'd2, 14'h0001);  // read to closed bank -> R9 error
        apply(1, 0, 3'b011, 3'd2, 14'h0002);
        apply(1, 0, 3'b011, 3'd2, 14'h0003);  // activate to open bank -> R9 error
        apply(1, 0, 3'b011, 3'd5, 14'h3fff);
        apply(1, 0, 3'b010, 3'd5, 14'h0000);  // R6 single precharge of bank 5
        apply(1, 0, 3'b011, 3'd7, 14'h0100);
        apply(1, 0, 3'b010, 3'd1, 14'h0400);  // R6 precharge all
        apply(1, 0, 3'b000, 3'd2, 14'h0123);  // R7 load mode, register 2
        apply(1, 0, 3'b000, 3'd7, 14'h2a5a);  // R7 ba[2] ignored, register 3
        apply(1, 0, 3'b001, 3'd3, 14'h0000);
        apply(1, 0, 3'b111, 3'd3, 14'h0000);
        apply(1, 0, 3'b110, 3'd3, 14'h0000);
        apply(1, 1, 3'b011, 3'd1, 14'h0011);  // R2 deselect with strobes asserted
        apply(0, 0, 3'b011, 3'd1, 14'h0011);  // R8 activate suppressed by cke
        apply(1, 0, 3'b101, 3'd1, 14'h0011);  // bank 1 still closed -> error
        apply(1, 0, 3'b011, 3'd6, 14'h0042);
        apply(0, 0, 3'b010, 3'd6, 14'h0400);  // R8 precharge all suppressed
        apply(1, 0, 3'b100, 3'd6, 14'h0009);  // bank 6 still open, no error

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic k, c;
            k = ($urandom % 10) != 0;
            c = ($urandom % 8) == 0;
            apply(k, c, 3'($urandom), 3'($urandom), 14'($urandom));
        end
        apply(1, 1, 3'b111, 3'd0, 14'h0);
        compare_all();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule